// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a local countdown timer with four word registers behind a single-address read/write port: a start-value register, a live count that can only be read, a clock-divider setting and a control entry. The control entry holds an interrupt vector, a suppress bit and a repeat bit. The count steps down once per prescaled tick. The divider setting picks a power-of-two ratio between 1 and 128.

When the count reaches zero, the timer raises a one-cycle request that carries the vector from the control entry. The suppress bit blocks this request. In one-shot operation the count then stays at zero. In repeat operation the count reloads the start value on the next tick, so each period lasts the start value plus one ticks. Writing the start value restarts both the count and the prescaler. A start value of zero leaves the timer idle.

Top module: `prescaled_countdown_timer`

## Requirements
- R1: The divider register at word offset 0x3E keeps only bits 3, 1 and 0 of a write. Its other bits read back as 0. After reset it reads 0.
- R2: The divider setting forms a 3-bit code with setting bit 3 as the MSB and setting bits [1:0] as the low bits. The tick rate is one tick every 2^((code+1) mod 8) clock cycles, so code 0b111 ticks every cycle and code 0b000 ticks every second cycle.
- R3: A write to offset 0x38 stores the start value, which reads back at 0x38. From the next cycle the live count at 0x39 shows that value. The prescaler restarts, so the first decrement comes exactly one tick period after the write edge.
- R4: When bit 17 of the control entry is 0 (one-shot), the count drops by one per tick, reaches zero and stays at zero.
- R5: When control bit 17 is 1 (repeat), a tick at zero reloads the start value. Expiries are then start value plus one ticks apart.
- R6: When a tick moves the count from 1 to 0 and control bit 16 is 0, `irq_valid` is high for exactly the following cycle. In that cycle `irq_vector` equals control bits [7:0].
- R7: When control bit 16 is 1, no request is raised, and counting goes on unchanged.
- R8: A start value of zero keeps the live count at zero and raises no request in either mode.
- R9: A write to offset 0x39 has no effect on the live count or its timing.
- R10: The control entry at offset 0x32 keeps bits 17, 16 and 7:0 and resets to 0x00010000 (suppressed, one-shot, vector 0). Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 8 | Word offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_valid | output | 1 | One-cycle interrupt request on expiry |
| irq_vector | output | 8 | Vector that goes with `irq_valid` |

## Verification
The count is tried under every divider code, in both one-shot and repeat modes, with start values of zero, one and larger. Directed cases fix the two edge codes, divide-by-1 and divide-by-2, and these separate an off-by-one in the code-to-ratio mapping from a wrong bit split. The random runs draw all eight codes and also set the divider bits that are dropped, which exposes a register that keeps stray bits. A restart in the middle of a run, a write to the live count in the middle of a run, and a suppressed entry are each checked cycle by cycle against a closed-form model of count and request. This tells a prescaler that is not restarted, or a reload that is late by one tick, apart from correct behaviour.

// File: rtl/cdt_pkg.sv
// Package: shared offsets, field positions and the control-entry type for
// the prescaled countdown timer. Assumes 32-bit data and 8-bit word offsets.
package cdt_pkg;

    localparam int unsigned CODE_W = 3;
    localparam int unsigned PRE_W  = (1 << CODE_W) - 1;
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned DIVR_W = 4;

    localparam logic [7:0] OFF_CTRL  = 8'h32;
    localparam logic [7:0] OFF_START = 8'h38;
    localparam logic [7:0] OFF_LIVE  = 8'h39;
    localparam logic [7:0] OFF_DIVR  = 8'h3E;

    localparam int unsigned CTRL_SUPPRESS_BIT = 16;
    localparam int unsigned CTRL_REPEAT_BIT   = 17;

    localparam logic [DIVR_W-1:0] DIVR_KEEP = 4'b1011;

    typedef struct packed {
        logic             repeat_en;
        logic             suppress;
        logic [VEC_W-1:0] vector;
    } ctrl_t;

    // Fold the kept divider bits into the 3-bit ratio code.
    function automatic logic [CODE_W-1:0] ratio_code(input logic [DIVR_W-1:0] setting);
        return {setting[3], setting[1:0]};
    endfunction

endpackage

// File: rtl/cdt_regs.sv
// Register file: holds start value, control entry and divider setting,
// decodes writes and muxes reads. Assumes DATA_W >= 18 so that the
// control fields fit. Reads are combinational on addr.
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] live_cnt,
    output logic [DATA_W-1:0] start_q,
    output logic              start_wr,
    output ctrl_t             ctrl_q,
    output logic [DIVR_W-1:0] divr_q,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_DIV = DATA_W - DIVR_W;

    logic ctrl_wr;
    logic divr_wr;

    // Write strobe decode per register.
    always_comb begin
        start_wr = wr_en && (addr == ADDR_W'(OFF_START));
        ctrl_wr  = wr_en && (addr == ADDR_W'(OFF_CTRL));
        divr_wr  = wr_en && (addr == ADDR_W'(OFF_DIVR));
    end

    // Start value storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= '0;
        else if (start_wr) start_q <= wdata;
    end

    // Control entry storage; resets suppressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.repeat_en <= 1'b0;
            ctrl_q.suppress  <= 1'b1;
            ctrl_q.vector    <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.repeat_en <= wdata[CTRL_REPEAT_BIT];
            ctrl_q.suppress  <= wdata[CTRL_SUPPRESS_BIT];
            ctrl_q.vector    <= wdata[VEC_W-1:0];
        end
    end

    // Divider setting storage, keeping only the defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       divr_q <= '0;
        else if (divr_wr) divr_q <= wdata[DIVR_W-1:0] & DIVR_KEEP;
    end

    // Read mux; the live count is read-only, unmapped offsets give zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_START): rdata = start_q;
            ADDR_W'(OFF_LIVE):  rdata = live_cnt;
            ADDR_W'(OFF_DIVR):  rdata = {{PAD_DIV{1'b0}}, divr_q};
            ADDR_W'(OFF_CTRL): begin
                rdata[CTRL_REPEAT_BIT]   = ctrl_q.repeat_en;
                rdata[CTRL_SUPPRESS_BIT] = ctrl_q.suppress;
                rdata[VEC_W-1:0]         = ctrl_q.vector;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/cdt_prescaler.sv
// Prescaler: free-running counter that raises tick for one cycle out of
// every 2^((code+1) mod 8). Assumes the code may change at any time; a
// restart clears the counter so the next tick is a full period away.
module cdt_prescaler
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    logic [CODE_W-1:0] shift;
    logic [PRE_W-1:0]  low_mask;
    logic [PRE_W-1:0]  pre_cnt;

    // Ratio exponent, wrapping so the top code means divide-by-1.
    always_comb shift = code + CODE_W'(1);

    // Low-bit mask with 'shift' ones, one bit per generate slice.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign low_mask[i] = (CODE_W'(i) < shift);
    end

    // Free-running count, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre_cnt <= '0;
        else                   pre_cnt <= pre_cnt + PRE_W'(1);
    end

    // Tick when all masked low bits are set.
    always_comb tick = ((pre_cnt & low_mask) == low_mask);

endmodule

// File: rtl/cdt_counter.sv
// Countdown core: loads the start value, decrements on ticks, reloads in
// repeat mode and flags expiry on the 1->0 step. The request is
// registered, so it appears in the cycle after that step. A load takes
// priority over a tick and suppresses any request in the same cycle.
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  ctrl_t            ctrl,
    output logic [CNT_W-1:0] cnt,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);

    logic at_zero;
    logic expire;

    // Expiry is the tick that takes the count from one to zero.
    always_comb begin
        at_zero = (cnt == '0);
        expire  = tick && !load && (cnt == CNT_W'(1));
    end

    // Count update: load, then decrement, then reload at zero in repeat mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (load)                   cnt <= load_val;
        else if (tick && !at_zero)       cnt <= cnt - CNT_W'(1);
        else if (tick && ctrl.repeat_en) cnt <= reload_val;
    end

    // Registered request pulse with its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= expire && !ctrl.suppress;
            if (expire) irq_vector <= ctrl.vector;
        end
    end

endmodule

// File: rtl/prescaled_countdown_timer.sv
// Top: register port, prescaler and countdown core. Assumes a single
// clock and a synchronous active-low reset; a write to the start value
// restarts the prescaler in the same edge that loads the count.
module prescaled_countdown_timer
    import cdt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [DATA_W-1:0] start_q;
    logic              start_wr;
    ctrl_t             ctrl_q;
    logic [DIVR_W-1:0] divr_q;
    logic [DATA_W-1:0] live_cnt;
    logic              tick;

    cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .live_cnt (live_cnt),
        .start_q  (start_q),
        .start_wr (start_wr),
        .ctrl_q   (ctrl_q),
        .divr_q   (divr_q),
        .rdata    (rdata)
    );

    cdt_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_wr),
        .code    (ratio_code(divr_q)),
        .tick    (tick)
    );

    cdt_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_wr),
        .load_val   (wdata),
        .reload_val (start_q),
        .tick       (tick),
        .ctrl       (ctrl_q),
        .cnt        (live_cnt),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/cdt_checker.sv
// Checker: temporal properties of the countdown timer, bound to the top.
module cdt_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_wr,
    input logic [CNT_W-1:0] wdata,
    input logic [CNT_W-1:0] start_q,
    input logic [CNT_W-1:0] live_cnt,
    input logic             tick,
    input logic             repeat_en,
    input logic             suppress,
    input logic             irq_valid
);

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> live_cnt == $past(wdata));

    // R4
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!repeat_en && live_cnt == '0 && !start_wr) |=> live_cnt == '0);

    // R5
    repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_en && tick && !start_wr && live_cnt == '0) |=> live_cnt == $past(start_q));

    // R6
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (live_cnt == '0 && $past(live_cnt) == CNT_W'(1)));

    // R7
    irq_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(suppress));

    // R8
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q == '0) |-> !irq_valid);

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_wr && !tick) |=> $stable(live_cnt));

endmodule

bind prescaled_countdown_timer cdt_checker #(.CNT_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_wr  (start_wr),
    .wdata     (wdata),
    .start_q   (start_q),
    .live_cnt  (live_cnt),
    .tick      (tick),
    .repeat_en (ctrl_q.repeat_en),
    .suppress  (ctrl_q.suppress),
    .irq_valid (irq_valid)
);

// File: tb/tb_prescaled_countdown_timer.sv
module tb_prescaled_countdown_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h39;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    bit          model_ok = 0;
    logic [31:0] m_start = 0;
    logic [31:0] m_divr = 0;
    bit          m_rep = 0, m_sup = 1;
    logic [7:0]  m_vec = 0;
    longint      t = 0;

    prescaled_countdown_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always #4 clk = ~clk;

    function automatic longint ratio(input logic [31:0] s);
        int code = {s[3], s[1], s[0]};
        return longint'(1) << ((code + 1) % 8);
    endfunction

    function automatic logic [31:0] exp_live(input longint tt);
        longint k = tt / ratio(m_divr);
        longint n = longint'(m_start);
        if (n == 0) return 32'd0;
        if (m_rep) return 32'(n - (k % (n + 1)));
        return (k >= n) ? 32'd0 : 32'(n - k);
    endfunction

    function automatic bit exp_irq(input longint tt);
        longint d = ratio(m_divr);
        longint k = tt / d;
        longint n = longint'(m_start);
        if (m_sup || n == 0 || (tt % d) != 0 || k == 0) return 0;
        if (m_rep) return (k % (n + 1)) == n;
        return k == n;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0d", req, act, expv, t);
        end
    endtask

    // Compare live count and request against the model.
    task automatic check_now();
        logic [31:0] el = exp_live(t);
        bit ei = exp_irq(t);
        chk(rdata == el, m_rep ? "R5 repeat count" : "R4 one-shot count", rdata, el);
        chk(irq_valid == ei, m_sup ? "R7 suppressed request" : "R6 request pulse",
            {31'd0, irq_valid}, {31'd0, ei});
        if (ei) chk(irq_vector == m_vec, "R6 vector", {24'd0, irq_vector}, {24'd0, m_vec});
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            t++;
            @(negedge clk);
            #1;
            if (model_ok) check_now();
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        if (a == 8'h38) begin
            t = 0; m_start = d; model_ok = 1;
        end else begin
            t++;
            if (a == 8'h32) begin
                m_rep = d[17]; m_sup = d[16]; m_vec = d[7:0]; model_ok = 0;
            end
            if (a == 8'h3E) begin
                m_divr = d & 32'hB; model_ok = 0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h39;
        #1;
        if (model_ok) check_now();
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] expv, input string req);
        addr = a;
        #1;
        chk(rdata == expv, req, rdata, expv);
        addr = 8'h39;
        #1;
    endtask

    function automatic logic [31:0] ctrl_word(input bit rep, input bit sup, input logic [7:0] v);
        return {14'd0, rep, sup, 8'd0, v};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state (R1, R10, R3)
        rd(8'h39, 32'd0, "R3 reset live");
        rd(8'h38, 32'd0, "R3 reset start");
        rd(8'h3E, 32'd0, "R1 reset divider");
        rd(8'h32, 32'h0001_0000, "R10 reset control");
        rd(8'h10, 32'd0, "R10 unmapped read");
        chk(irq_valid == 1'b0, "R6 reset request", {31'd0, irq_valid}, 32'd0);

        // R2 code 111 = divide-by-1, R5 repeat, R6 vector
        wr(8'h3E, 32'h0000_000B);
        wr(8'h32, ctrl_word(1, 0, 8'h41));
        rd(8'h32, 32'h0002_0041, "R10 control readback");
        wr(8'h38, 32'd3);
        rd(8'h38, 32'd3, "R3 start readback");
        step(14);

        // R2 code 000 = divide-by-2, R4 one-shot hold
        wr(8'h3E, 32'h0);
        wr(8'h32, ctrl_word(0, 0, 8'h22));
        wr(8'h38, 32'd4);
        step(16);

        // R8 zero start in repeat mode
        wr(8'h32, ctrl_word(1, 0, 8'h55));
        wr(8'h38, 32'd0);
        step(20);

        // R9 write to live count ignored (code 001 = divide-by-4)
        wr(8'h3E, 32'h1);
        wr(8'h32, ctrl_word(0, 0, 8'h09));
        wr(8'h38, 32'd5);
        step(6);
        wr(8'h39, 32'h77);
        step(20);

        // R3 restart mid-run
        wr(8'h32, ctrl_word(1, 0, 8'h6A));
        wr(8'h38, 32'd6);
        step(9);
        wr(8'h38, 32'd2);
        step(15);

        // R7 suppressed entry, divide-by-1
        wr(8'h3E, 32'hB);
        wr(8'h32, ctrl_word(1, 1, 8'h7F));
        wr(8'h38, 32'd2);
        step(12);

        // R1 stray divider bits dropped
        wr(8'h3E, 32'hFFFF_FFFF);
        rd(8'h3E, 32'h0000_000B, "R1 divider mask");

        // random runs
        for (int it = 0; it < 20; it++) begin
            logic [31:0] dv = $urandom;
            logic [31:0] cw = $urandom;
            logic [31:0] n = $urandom_range(0, 9);
            wr(8'h3E, dv);
            rd(8'h3E, dv & 32'hB, "R1 random divider");
            wr(8'h32, cw);
            rd(8'h32, cw & 32'h0003_00FF, "R10 random control");
            wr(8'h38, n);
            step(int'((n + 2) * ratio(m_divr) * 2) + 3);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule